// File: doc/BRIEF.md
# Timer Tick Source Selector

This block decides when a timer register may advance. It produces `tick_o`, a pulse one system clock wide, which the timer uses as its count enable. A 3-bit select input chooses the source of the ticks. The block can stop the timer, tick on every clock, or divide the clock by 8, 64, 256 or 1024. It can also count rising or falling edges of an external pin.

The divided rates come from one free-running 10-bit prescale counter. This counter advances on every clock whatever the select is. A divided tick is raised when the low bits of the counter, as many as the ratio needs, are all ones. The external pin is asynchronous. It passes through a two-flop synchronizer and then an edge detector. All sources meet at a multiplexer, and one output register drives `tick_o`. Every tick is therefore registered and lasts exactly one cycle. As an example, a 16 MHz clock with the 1024 ratio gives 15625 ticks per second.

Top module: `timer_tick_gen`

## Requirements
- R1: While `rst_i` is high, `tick_o` is low and the prescale counter and synchronizer flops are cleared. With select 010 held through the release of reset, the first tick appears after the 8th rising clock edge following release.
- R2: Select 000 gives no tick: `tick_o` stays low in every cycle after an edge sampled with that select.
- R3: Select 001 makes `tick_o` high after every clock edge sampled with that select.
- R4: Selects 010, 011, 100 and 101 use the low 3, 6, 8 and 10 counter bits respectively. `tick_o` is high in the cycle after those bits were all ones. This gives one tick per 8, 64, 256 and 1024 cycles.
- R5: In the divided modes a tick lasts exactly one cycle. It is never followed by a second tick while a divided select stays applied.
- R6: Select 110 ticks on falling edges of `ext_pin_i` and select 111 on rising edges. The tick appears after the third rising clock edge that follows the pin change.
- R7: A single edge of the selected polarity gives exactly one tick. An edge of the other polarity gives none.
- R8: The prescale counter advances by one on every clock outside reset, under any select. Changing the select does not disturb the divided phase.
- R9: With select 101, any 16384 consecutive cycles contain exactly 16 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| select_i | input | 3 | Tick source select |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | One-cycle count enable |

## Verification
The assertions assume that reset is high from time zero and lasts at least one clock edge. They also assume that `select_i` only changes away from the rising edge, so every edge samples a settled value. The stimulus drives the select and the pin only at falling clock edges, and it holds reset for several cycles at the start. Select changes come at random intervals, with every code allowed at every counter phase. This exercises the divided-phase and one-wide-tick properties across mode switches.

// File: rtl/tick_sel_pkg.sv
package tick_sel_pkg;

  typedef enum logic [2:0] {
    SEL_OFF      = 3'd0,
    SEL_DIV1     = 3'd1,
    SEL_DIV8     = 3'd2,
    SEL_DIV64    = 3'd3,
    SEL_DIV256   = 3'd4,
    SEL_DIV1024  = 3'd5,
    SEL_PIN_FALL = 3'd6,
    SEL_PIN_RISE = 3'd7
  } tick_sel_e;

  localparam int NUM_TAPS = 4;

  // number of low counter bits that must be all ones for divider tap idx
  function automatic int tap_width(input int idx);
    case (idx)
      0:       return 3;
      1:       return 6;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic is_divided(input logic [2:0] sel);
    return (sel >= 3'd2) && (sel <= 3'd5);
  endfunction

endpackage

// File: rtl/prescale_counter.sv
module prescale_counter
  import tick_sel_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic                clk_i,
  input  logic                rst_i,
  output logic [NUM_TAPS-1:0] tap_hit_o
);

  logic [CNT_W-1:0] cnt_q;

  // free running, independent of the select
  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
    localparam int TW = tap_width(t);
    assign tap_hit_o[t] = &cnt_q[TW-1:0];
  end

  // R8: counter steps by one every cycle outside reset
  p_count_step_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o =  sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] &  last_q;

endmodule

// File: rtl/tick_mux.sv
module tick_mux
  import tick_sel_pkg::*;
(
  input  tick_sel_e           sel_i,
  input  logic [NUM_TAPS-1:0] tap_hit_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_next_o
);

  always_comb begin
    unique case (sel_i)
      SEL_OFF:      tick_next_o = 1'b0;
      SEL_DIV1:     tick_next_o = 1'b1;
      SEL_DIV8:     tick_next_o = tap_hit_i[0];
      SEL_DIV64:    tick_next_o = tap_hit_i[1];
      SEL_DIV256:   tick_next_o = tap_hit_i[2];
      SEL_DIV1024:  tick_next_o = tap_hit_i[3];
      SEL_PIN_FALL: tick_next_o = fall_i;
      SEL_PIN_RISE: tick_next_o = rise_i;
      default:      tick_next_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen
  import tick_sel_pkg::*;
#(
  parameter int PRESCALE_W  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [2:0] select_i,
  input  logic       ext_pin_i,
  output logic       tick_o
);

  localparam int MIN_W = tap_width(NUM_TAPS - 1);
  if (PRESCALE_W < MIN_W) begin : g_bad_width
    initial $error("PRESCALE_W too small for largest divider");
  end

  logic [NUM_TAPS-1:0] tap_hit;
  logic                pin_rise, pin_fall, tick_next;

  prescale_counter #(.CNT_W(PRESCALE_W)) u_count (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tap_hit_o(tap_hit)
  );

  pin_edge_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .pin_i (ext_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  tick_mux u_mux (
    .sel_i      (tick_sel_e'(select_i)),
    .tap_hit_i  (tap_hit),
    .rise_i     (pin_rise),
    .fall_i     (pin_fall),
    .tick_next_o(tick_next)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) tick_o <= 1'b0;
    else       tick_o <= tick_next;
  end

  // R2: stop select yields no tick
  p_stop_quiet_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    select_i == 3'd0 |=> !tick_o);

  // R3: undivided select ticks every cycle
  p_every_cycle_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    select_i == 3'd1 |=> tick_o);

  // R5: divided ticks are one cycle wide
  p_one_wide_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (tick_o && is_divided($past(select_i)) && is_divided(select_i)) |=> !tick_o);

endmodule

// File: tb/test_timer_tick_gen.sv
module test_timer_tick_gen;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel = 3'd1;
  logic       pin = 1'b0;
  logic       tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_tick_gen i_timer_tick_gen (
    .clk_i    (clk),
    .rst_i    (rst),
    .select_i (sel),
    .ext_pin_i(pin),
    .tick_o   (tick)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model built from the requirements
  logic [9:0] mcnt;
  logic       p1, p2, p3, exp_q;

  function automatic logic exp_tick(input logic [2:0] s, input logic [9:0] c,
                                    input logic newer, input logic older);
    case (s)
      3'd0: return 1'b0;
      3'd1: return 1'b1;
      3'd2: return &c[2:0];
      3'd3: return &c[5:0];
      3'd4: return &c[7:0];
      3'd5: return &c[9:0];
      3'd6: return older & ~newer;
      default: return newer & ~older;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] s);
    case (s)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd6, 3'd7: return "R6";
      default: return "R4";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mcnt <= '0; p1 <= 1'b0; p2 <= 1'b0; p3 <= 1'b0; exp_q <= 1'b0;
    end else begin
      mcnt  <= mcnt + 1'b1;
      p1    <= pin;
      p2    <= p1;
      p3    <= p2;
      exp_q <= exp_tick(sel, mcnt, p2, p3);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  logic [2:0] prev_sel = 3'd1;

  // one cycle: compare at the falling edge, then caller may drive inputs
  task automatic step(output bit t);
    @(negedge clk);
    if (!rst)
      check(tick === exp_q, req_of(prev_sel), int'(tick), int'(exp_q));
    t = tick;
    prev_sel = sel;
  endtask

  task automatic count_ticks(input int n, output int c);
    bit t;
    c = 0;
    for (int i = 0; i < n; i++) begin
      step(t);
      if (t) c++;
    end
  endtask

  initial begin
    bit t;
    int c;
    void'($urandom(32'd5171));
    // R1: reset holds the output low
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pin = ~pin;
      check(tick === 1'b0, "R1", int'(tick), 0);
    end
    pin = 1'b0;
    sel = 3'd2;
    prev_sel = sel;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: first divide-by-8 tick after the 8th edge
    for (int i = 1; i <= 8; i++) begin
      step(t);
      check(t == (i == 8), "R1", int'(t), int'(i == 8));
    end
    // R2: stopped
    sel = 3'd0; step(t);
    count_ticks(300, c);
    check(c == 0, "R2", c, 0);
    // R3: every cycle
    sel = 3'd1; step(t);
    count_ticks(100, c);
    check(c == 100, "R3", c, 100);
    // R4: fixed dividers, window of 2048 cycles
    for (int s = 2; s <= 5; s++) begin
      sel = 3'(s); step(t);
      count_ticks(2048, c);
      check(c == 2048 >> (s == 2 ? 3 : s == 3 ? 6 : s == 4 ? 8 : 10), "R4", c,
            2048 >> (s == 2 ? 3 : s == 3 ? 6 : s == 4 ? 8 : 10));
    end
    // R9: 16 ticks in 16384 cycles at the largest ratio
    count_ticks(16384, c);
    check(c == 16, "R9", c, 16);
    // R8: phase survives a detour through stop and pin modes
    sel = 3'd0; count_ticks(37, c);
    sel = 3'd7; count_ticks(11, c);
    sel = 3'd2; step(t);
    count_ticks(64, c);
    check(c == 8, "R8", c, 8);
    // R7: single edges
    sel = 3'd7; pin = 1'b0; count_ticks(10, c);
    pin = 1'b1; count_ticks(10, c);
    check(c == 1, "R7", c, 1);
    sel = 3'd6; count_ticks(10, c);
    check(c == 0, "R7", c, 0);
    pin = 1'b0; count_ticks(10, c);
    check(c == 1, "R7", c, 1);
    sel = 3'd7; pin = 1'b1; count_ticks(10, c);
    pin = 1'b0; count_ticks(10, c);
    check(c == 0, "R7", c, 0);
    // R6: edge latency of three clocks
    sel = 3'd7; pin = 1'b1;
    step(t); step(t);
    check(t == 1'b0, "R6", int'(t), 0);
    step(t);
    check(t == 1'b1, "R6", int'(t), 1);
    // random mix, every cycle compared against the model
    for (int i = 0; i < 20000; i++) begin
      step(t);
      if ($urandom_range(63) == 0) sel = 3'($urandom_range(7));
      if ($urandom_range(3) == 0) pin = ~pin;
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule